// File: doc/BRIEF.md
# Interrupt Status, Mask and Doorbell Register Block

This block is the interrupt front end of a storage host adapter's register window. Two internal events set bits in a status register: a completion batch and a posted message. Software reads that register, clears bits by writing ones to them, and chooses which bits may interrupt through a full-width enable mask. The interrupt condition is the OR of the masked status bits.

The condition is signalled in one of two ways, chosen by the `msg_mode` input. In legacy mode a level line follows the condition. In message mode a one-cycle notification pulse is sent whenever the condition is found true after a status or mask update. Nothing is sent when the condition falls, and the pulse is never withdrawn.

The same register decoder turns writes to either of two doorbell offsets into a ring-processing request pulse. A status write also raises a retry pulse for pending completion delivery. The decoder returns status, mask and an externally supplied command status on reads. Every access is one aligned 32-bit word. Every other offset is inert.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the status bits and the mask read as zero, and `irq_level`, `irq_msg_pulse`, `kick_req`, `cmpl_retry` and `reg_rdata` are all zero.
- R2: A write to offset 0x00 clears each status bit whose written bit is one and leaves every other status bit unchanged.
- R3: A write to offset 0x04 replaces the whole 32-bit mask with the written word. Reading 0x04 returns it, and no other access changes it.
- R4: An `evt_cmpl` pulse sets status bit 0 and an `evt_msg` pulse sets status bit 1. An event in the same cycle as a clearing write to that bit wins, so the bit ends set.
- R5: While `msg_mode` is 0, `irq_level` equals the OR of (mask AND status) from the current register values. While `msg_mode` is 1, `irq_level` is 0.
- R6: While `msg_mode` is 1, `irq_msg_pulse` is high for one cycle, in the cycle after any event, status write or mask write whose updated condition is true. It stays low when the updated condition is false, and it stays low when only `msg_mode` changes. While `msg_mode` is 0, it stays low.
- R7: A write to offset 0x00 raises `cmpl_retry` for exactly the following cycle.
- R8: A write to offset 0x0C or 0x10 raises `kick_req` for exactly the following cycle.
- R9: Writes to the debug offset 0x14, to any unmapped offset, or to any address whose two low bits are not zero change nothing. Reads of anything other than 0x00, 0x04 and 0x08 return zero. Status bits 31..2 read as zero.
- R10: A read of offset 0x08 returns the value on `cmd_status_in`.
- R11: `reg_rdata` is registered. It shows the addressed value in the cycle after `reg_rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe, one word per cycle |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_status_in | input | 32 | Command status value supplied by the command engine |
| evt_cmpl | input | 1 | One-cycle completion-batch event |
| evt_msg | input | 1 | One-cycle message-posted event |
| msg_mode | input | 1 | 1 selects message-signalled notification, 0 selects level line |
| irq_level | output | 1 | Level interrupt in legacy mode |
| irq_msg_pulse | output | 1 | One-cycle notification in message mode |
| kick_req | output | 1 | One-cycle request to process the request ring |
| cmpl_retry | output | 1 | One-cycle request to retry completion delivery |

## Verification
A vector table drives the main function through several kinds of change: event-only sets, mask-only changes, and selective one-bit clears, all under both output modes. These separate a wrong mask AND, a clear that hits the wrong bit, and notifications sent on the wrong transition. Mask values that enable one bit at a time expose a condition built from the wrong bit. Message-mode steps in which the condition turns false must give no pulse, which catches a design that notifies on every update. Directed cases cover an event colliding with a clear, a mode switch while the condition is true, misaligned and unmapped offsets, and the hold of read data.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // status bit layout
  localparam int unsigned STAT_BITS = 2;
  localparam int unsigned CMPL_BIT  = 0;
  localparam int unsigned MSG_BIT   = 1;

  // word offsets in the register window
  localparam int unsigned OFF_STATUS = 'h00;
  localparam int unsigned OFF_MASK   = 'h04;
  localparam int unsigned OFF_CMDST  = 'h08;
  localparam int unsigned OFF_KICK_A = 'h0C;
  localparam int unsigned OFF_KICK_B = 'h10;
  localparam int unsigned OFF_DEBUG  = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_MASK,
    SEL_CMDST,
    SEL_KICK,
    SEL_DBG
  } reg_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [STAT_BITS-1:0] stat_q,
  input  logic [DATA_W-1:0]    mask_q,
  input  logic [DATA_W-1:0]    cmd_status,
  output logic                 wr_stat,
  output logic                 wr_mask,
  output logic                 kick_q,
  output logic                 retry_q,
  output logic [DATA_W-1:0]    rdata_q
);

  reg_sel_e          sel;
  logic              aligned;
  logic              kick_d;
  logic              retry_d;
  logic [DATA_W-1:0] rdata_d;

  assign aligned = (reg_addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (reg_addr == ADDR_W'(OFF_STATUS))      sel = SEL_STAT;
      else if (reg_addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
      else if (reg_addr == ADDR_W'(OFF_CMDST))  sel = SEL_CMDST;
      else if (reg_addr == ADDR_W'(OFF_KICK_A)) sel = SEL_KICK;
      else if (reg_addr == ADDR_W'(OFF_KICK_B)) sel = SEL_KICK;
      else if (reg_addr == ADDR_W'(OFF_DEBUG))  sel = SEL_DBG;
      else                                      sel = SEL_NONE;
    end
  end

  // write side: debug and unmapped targets produce no strobe
  assign wr_stat = reg_wr_en && (sel == SEL_STAT);
  assign wr_mask = reg_wr_en && (sel == SEL_MASK);
  assign kick_d  = reg_wr_en && (sel == SEL_KICK);
  assign retry_d = wr_stat;

  // read side
  always_comb begin
    case (sel)
      SEL_STAT:  rdata_d = DATA_W'(stat_q);
      SEL_MASK:  rdata_d = mask_q;
      SEL_CMDST: rdata_d = cmd_status;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      kick_q  <= kick_d;
      retry_q <= retry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic                 mask_wr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [STAT_BITS-1:0] stat_set,
  output logic [STAT_BITS-1:0] stat_q,
  output logic [DATA_W-1:0]    mask_q,
  output logic                 cond,
  output logic                 cond_next,
  output logic                 reeval
);

  logic [STAT_BITS-1:0] stat_d;
  logic [DATA_W-1:0]    mask_d;
  logic                 stat_en;

  // per bit: a set event overrides a simultaneous one-to-clear
  generate
    for (genvar b = 0; b < STAT_BITS; b++) begin : g_bit
      assign stat_d[b] = stat_set[b] | (stat_q[b] & ~(clr_en & wdata[b]));
    end
  endgenerate

  assign stat_en = clr_en | (|stat_set);
  assign mask_d  = mask_wr ? wdata : mask_q;

  assign cond      = |(mask_q[STAT_BITS-1:0] & stat_q);
  assign cond_next = |(mask_d[STAT_BITS-1:0] & stat_d);
  assign reeval    = stat_en | mask_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_notify.sv
module irq_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_mode,
  input  logic cond,
  input  logic cond_next,
  input  logic reeval,
  output logic irq_level,
  output logic irq_msg_pulse
);

  logic pulse_d;
  logic pulse_q;

  // message mode: notify only when an update leaves the condition true
  assign pulse_d = msg_mode & reeval & cond_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign irq_level     = ~msg_mode & cond;
  assign irq_msg_pulse = pulse_q;

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] cmd_status_in,
  input  logic              evt_cmpl,
  input  logic              evt_msg,
  input  logic              msg_mode,
  output logic              irq_level,
  output logic              irq_msg_pulse,
  output logic              kick_req,
  output logic              cmpl_retry
);

  logic                 rst_sync_n;
  logic                 wr_stat;
  logic                 wr_mask;
  logic [STAT_BITS-1:0] stat_set;
  logic [STAT_BITS-1:0] stat_q;
  logic [DATA_W-1:0]    mask_q;
  logic                 cond;
  logic                 cond_next;
  logic                 reeval;

  always_comb begin
    stat_set           = '0;
    stat_set[CMPL_BIT] = evt_cmpl;
    stat_set[MSG_BIT]  = evt_msg;
  end

  irq_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .cmd_status (cmd_status_in),
    .wr_stat    (wr_stat),
    .wr_mask    (wr_mask),
    .kick_q     (kick_req),
    .retry_q    (cmpl_retry),
    .rdata_q    (reg_rdata)
  );

  irq_status_core #(.DATA_W(DATA_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_en    (wr_stat),
    .mask_wr   (wr_mask),
    .wdata     (reg_wdata),
    .stat_set  (stat_set),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .cond      (cond),
    .cond_next (cond_next),
    .reeval    (reeval)
  );

  irq_notify ntf_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .msg_mode      (msg_mode),
    .cond          (cond),
    .cond_next     (cond_next),
    .reeval        (reeval),
    .irq_level     (irq_level),
    .irq_msg_pulse (irq_msg_pulse)
  );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_mode,
  input logic                 irq_level,
  input logic                 irq_msg_pulse,
  input logic                 kick_req,
  input logic                 cmpl_retry,
  input logic                 reg_wr_en,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [STAT_BITS-1:0] wd_lo,
  input logic                 evt_cmpl,
  input logic                 evt_msg,
  input logic [STAT_BITS-1:0] stat_q,
  input logic [DATA_W-1:0]    mask_q
);

  // R4
  cmpl_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_cmpl) |-> stat_q[CMPL_BIT]);

  // R4
  msg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_msg) |-> stat_q[MSG_BIT]);

  // R2
  clear_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr_en && reg_addr == ADDR_W'(OFF_STATUS) && wd_lo[CMPL_BIT])
     && !$past(evt_cmpl)) |-> !stat_q[CMPL_BIT]);

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr_en) |-> $stable(mask_q));

  // R5
  level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq_level);

  // R6
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_pulse |-> $past(msg_mode));

  // R7
  retry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_retry |-> $past(reg_wr_en && reg_addr == ADDR_W'(OFF_STATUS)));

  // R8
  kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_req |-> $past(reg_wr_en));

endmodule

bind irq_ctrl_top irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .msg_mode      (msg_mode),
  .irq_level     (irq_level),
  .irq_msg_pulse (irq_msg_pulse),
  .kick_req      (kick_req),
  .cmpl_retry    (cmpl_retry),
  .reg_wr_en     (reg_wr_en),
  .reg_addr      (reg_addr),
  .wd_lo         (reg_wdata[irq_ctrl_pkg::STAT_BITS-1:0]),
  .evt_cmpl      (evt_cmpl),
  .evt_msg       (evt_msg),
  .stat_q        (stat_q),
  .mask_q        (mask_q)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_rd_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] cmd_status_in;
  logic        evt_cmpl;
  logic        evt_msg;
  logic        msg_mode;
  logic        irq_level;
  logic        irq_msg_pulse;
  logic        kick_req;
  logic        cmpl_retry;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_ctrl_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .cmd_status_in (cmd_status_in),
    .evt_cmpl      (evt_cmpl),
    .evt_msg       (evt_msg),
    .msg_mode      (msg_mode),
    .irq_level     (irq_level),
    .irq_msg_pulse (irq_msg_pulse),
    .kick_req      (kick_req),
    .cmpl_retry    (cmpl_retry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: op[48:47] (0 write, 1 event), mode[46], addr[45:38], data[37:6],
  //         level[5], pulse[4], kick[3], retry[2], status[1:0]
  localparam int NV = 17;
  localparam logic [48:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h00, 32'h0000_0001,       1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
    {2'd0, 1'b0, 8'h04, 32'h0000_0001,       1'b1, 1'b0, 1'b0, 1'b0, 2'b01},
    {2'd1, 1'b0, 8'h00, 32'h0000_0002,       1'b1, 1'b0, 1'b0, 1'b0, 2'b11},
    {2'd0, 1'b0, 8'h00, 32'h0000_0001,       1'b0, 1'b0, 1'b0, 1'b1, 2'b10},
    {2'd0, 1'b0, 8'h04, 32'h0000_0003,       1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h00, 32'h0000_0002,       1'b0, 1'b0, 1'b0, 1'b1, 2'b00},
    {2'd1, 1'b1, 8'h00, 32'h0000_0001,       1'b0, 1'b1, 1'b0, 1'b0, 2'b01},
    {2'd0, 1'b1, 8'h00, 32'h0000_0001,       1'b0, 1'b0, 1'b0, 1'b1, 2'b00},
    {2'd1, 1'b1, 8'h00, 32'h0000_0002,       1'b0, 1'b1, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b1, 8'h04, 32'h0000_0001,       1'b0, 1'b0, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b1, 8'h04, 32'h0000_0002,       1'b0, 1'b1, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b1, 8'h0C, 32'h0000_0000,       1'b0, 1'b0, 1'b1, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h10, 32'h0000_0000,       1'b1, 1'b0, 1'b1, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h14, 32'hFFFF_FFFF,       1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h01, 32'h0000_0003,       1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h40, 32'h0000_0003,       1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
    {2'd0, 1'b0, 8'h00, 32'hFFFF_FFFF,       1'b0, 1'b0, 1'b0, 1'b1, 2'b00}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1;
    reg_addr  = a;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    cmd_status_in = '0; evt_cmpl = 0; evt_msg = 0; msg_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports
    check("R1", "irq_level", 32'(irq_level), 0);
    check("R1", "irq_msg_pulse", 32'(irq_msg_pulse), 0);
    check("R1", "kick_req", 32'(kick_req), 0);
    check("R1", "cmpl_retry", 32'(cmpl_retry), 0);
    check("R1", "rdata", reg_rdata, 0);
    rd(8'h00, v); check("R1", "status", v, 0);
    rd(8'h04, v); check("R1", "mask", v, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [48:0] e;
      e = VEC[i];
      @(negedge clk);
      msg_mode = e[46];
      if (e[48:47] == 2'd1) begin
        evt_cmpl = e[6];
        evt_msg  = e[7];
      end else begin
        reg_wr_en = 1'b1;
        reg_addr  = e[45:38];
        reg_wdata = e[37:6];
      end
      @(posedge clk);
      @(negedge clk);
      check("R5", $sformatf("vec%0d level", i), 32'(irq_level), 32'(e[5]));
      check("R6", $sformatf("vec%0d pulse", i), 32'(irq_msg_pulse), 32'(e[4]));
      check("R8", $sformatf("vec%0d kick", i), 32'(kick_req), 32'(e[3]));
      check("R7", $sformatf("vec%0d retry", i), 32'(cmpl_retry), 32'(e[2]));
      evt_cmpl = 0; evt_msg = 0; reg_wr_en = 0;
      rd(8'h00, v);
      check("R2", $sformatf("vec%0d status", i), v, 32'(e[1:0]));
    end

    // R3: full-width mask replacement and read-back
    wr(8'h04, 32'hA5A5_0002);
    rd(8'h04, v); check("R3", "mask readback", v, 32'hA5A5_0002);

    // R4: event beats a simultaneous clear of the same bit
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 8'h00; reg_wdata = 32'h1; evt_cmpl = 1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 0; evt_cmpl = 0;
    rd(8'h00, v); check("R4", "set wins over clear", v, 32'h1);
    check("R5", "bit0 masked off", 32'(irq_level), 0);

    // R10: command status read-back
    cmd_status_in = 32'hDEAD_BEEF;
    rd(8'h08, v); check("R10", "cmd status", v, 32'hDEAD_BEEF);

    // R11: read data holds after the strobe drops
    cmd_status_in = 32'h1234_5678;
    repeat (2) @(negedge clk);
    check("R11", "rdata hold", reg_rdata, 32'hDEAD_BEEF);

    // R9: reads of inert offsets
    rd(8'h40, v); check("R9", "unmapped read", v, 0);
    rd(8'h05, v); check("R9", "misaligned read", v, 0);
    rd(8'h14, v); check("R9", "debug read", v, 0);
    rd(8'h0C, v); check("R9", "kick read", v, 0);

    // R6: switching mode with the condition true sends nothing
    @(negedge clk); evt_msg = 1;
    @(posedge clk); @(negedge clk); evt_msg = 0;
    check("R5", "legacy level high", 32'(irq_level), 1);
    msg_mode = 1;
    #1;
    check("R5", "level drops in msg mode", 32'(irq_level), 0);
    @(posedge clk); @(negedge clk);
    check("R6", "no pulse on mode switch", 32'(irq_msg_pulse), 0);
    // R6: clearing to a false condition sends nothing
    wr(8'h00, 32'h2);
    check("R6", "no pulse on deassert", 32'(irq_msg_pulse), 0);
    check("R7", "retry after status write", 32'(cmpl_retry), 1);
    @(negedge clk);
    check("R7", "retry one cycle", 32'(cmpl_retry), 0);

    // R1: reset mid-run clears status and mask
    msg_mode = 0;
    do_reset();
    rd(8'h00, v); check("R1", "status after reset", v, 0);
    rd(8'h04, v); check("R1", "mask after reset", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule